// File: doc/BRIEF.md
# Three-Wire Register Loader

This block is the serial configuration port of a frequency synthesizer. An external controller drives three slow lines: a serial clock, a data line and a load enable. The block samples all three on its own faster system clock, shifts in one bit on every rising edge of the serial clock, and treats a rising edge of the load enable as the end of a word. Each word carries 24 bits, most significant bit first. Its two final bits choose one of four destination registers, and the other 22 bits are the payload.

The four destinations are a reference-divider register, a feedback-counter register, a control register and a start-up register. A word aimed at the start-up register is written to the control register as well, with the same payload. When a register takes a new value, its update strobe is high for one system cycle, so that downstream logic can reload its counters. A word is accepted only when exactly 24 serial clock edges arrived since the previous load pulse. Any other count throws the word away and raises a frame-error flag. The flag stays high until the next accepted word.

Top module: `three_wire_loader`

## Requirements
- R1: After reset all four registers read zero, all update strobes are low and the frame-error flag is low.
- R2: Bits are taken on rising serial-clock edges, first bit first. The first of 24 bits becomes bit 21 of the payload and the 22nd becomes payload bit 0.
- R3: An accepted word whose last two bits (23rd then 24th) form the code 00 loads the reference register (`ref_word`) and pulses `ref_upd`.
- R4: Code 01 loads the counter register (`cnt_word`) and pulses `cnt_upd`.
- R5: Code 10 loads the control register (`func_word`) and pulses `func_upd`.
- R6: Code 11 loads both the start-up register (`init_word`) and the control register with the same payload. `init_upd` and `func_upd` pulse in the same cycle.
- R7: Each update strobe is high for exactly one system cycle per accepted word. Registers that the word does not select keep their values.
- R8: A word of fewer than 24 serial edges is discarded. No register or strobe changes, and `frame_err` goes high.
- R9: A word of more than 24 serial edges is discarded in the same way, with `frame_err` high.
- R10: `frame_err` stays high until the next accepted word, which clears it.
- R11: Each serial line passes through two synchronizer flops. The strobe is first seen high in the fourth system cycle after the load enable rises at the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on the rising edge of ser_clk |
| ser_le | input | 1 | Load enable; a rising edge ends a word |
| ref_word | output | 22 | Reference-divider register |
| cnt_word | output | 22 | Feedback-counter register |
| func_word | output | 22 | Control register |
| init_word | output | 22 | Start-up register |
| ref_upd | output | 1 | One-cycle strobe when ref_word is loaded |
| cnt_upd | output | 1 | One-cycle strobe when cnt_word is loaded |
| func_upd | output | 1 | One-cycle strobe when func_word is loaded |
| init_upd | output | 1 | One-cycle strobe when init_word is loaded |
| frame_err | output | 1 | High after a discarded word, until the next accepted word |

## Verification
Two register writes can land in the same cycle: a start-up word loads the start-up register and the control register together. The bench sends every code with walking-one payloads. For code 11 it expects both strobes in exactly the same cycle and both registers holding the identical payload. An embedded property also requires every start-up strobe to come with a control strobe and matching contents. Error clearing is tested next to these writes: a bad-length word is followed by a good one, and the flag is judged after each.

// File: rtl/twl_pkg.sv
package twl_pkg;
    localparam int WORD_W = 24;
    localparam int SEL_W  = 2;
    localparam int PAY_W  = WORD_W - SEL_W;
    localparam int N_DST  = 1 << SEL_W;
    localparam int CNT_W  = $clog2(WORD_W + 2);

    typedef enum logic [SEL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_CNT  = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } sel_e;

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic [WORD_W-1:0] word;
    } frame_t;

    function automatic sel_e sel_of(input logic [WORD_W-1:0] w);
        return sel_e'(w[SEL_W-1:0]);
    endfunction

    function automatic logic [PAY_W-1:0] payload_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:SEL_W];
    endfunction
endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
                prev  <= chain[STAGES-1];
            end
        end
        assign level[b] = chain[STAGES-1];
        assign rise[b]  = chain[STAGES-1] & ~prev;
    end
endmodule

// File: rtl/twl_shifter.sv
module twl_shifter
    import twl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_stb,
    input  logic   bit_val,
    input  logic   load_stb,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  edges;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            edges <= '0;
            frame <= '0;
        end else begin
            frame.valid <= 1'b0;
            if (load_stb) begin
                frame.valid <= 1'b1;
                frame.ok    <= (edges == FULL);
                frame.word  <= sreg;
                edges       <= '0;
            end else if (bit_stb) begin
                sreg <= {sreg[WORD_W-2:0], bit_val};
                if (edges != OVER) edges <= edges + 1'b1;
            end
        end
    end

    p_edges_sat_r9: assert property (@(posedge clk) disable iff (rst)
        edges <= OVER);
    p_count_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> edges == '0);
endmodule

// File: rtl/twl_bank.sv
module twl_bank
    import twl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  frame_t                      frame,
    output logic [N_DST-1:0][PAY_W-1:0] regs,
    output logic [N_DST-1:0]            upd,
    output logic                        err
);
    sel_e             sel;
    logic [PAY_W-1:0] pay;
    logic             take;

    assign sel  = sel_of(frame.word);
    assign pay  = payload_of(frame.word);
    assign take = frame.valid & frame.ok;

    for (genvar g = 0; g < N_DST; g++) begin : g_dst
        logic hit;
        if (g == int'(SEL_FUNC)) begin : g_shared
            assign hit = take & ((sel == SEL_FUNC) | (sel == SEL_INIT));
        end else begin : g_plain
            assign hit = take & (sel == sel_e'(g));
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
                upd[g]  <= 1'b0;
            end else begin
                upd[g] <= hit;
                if (hit) regs[g] <= pay;
            end
        end

        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !upd[g] |-> $stable(regs[g]));
        p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
            upd[g] |=> !upd[g]);
    end

    always_ff @(posedge clk) begin
        if (rst)              err <= 1'b0;
        else if (frame.valid) err <= ~frame.ok;
    end

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> upd == '0);
    p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (upd != '0) |-> !err);
endmodule

// File: rtl/three_wire_loader.sv
module three_wire_loader
    import twl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [PAY_W-1:0] ref_word,
    output logic [PAY_W-1:0] cnt_word,
    output logic [PAY_W-1:0] func_word,
    output logic [PAY_W-1:0] init_word,
    output logic             ref_upd,
    output logic             cnt_upd,
    output logic             func_upd,
    output logic             init_upd,
    output logic             frame_err
);
    localparam int LN_CLK = 0;
    localparam int LN_DAT = 1;
    localparam int LN_LE  = 2;

    logic [2:0]                  lvl, rise;
    frame_t                      frame;
    logic [N_DST-1:0][PAY_W-1:0] regs;
    logic [N_DST-1:0]            upd;

    twl_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_le, ser_data, ser_clk}),
        .level    (lvl),
        .rise     (rise)
    );

    twl_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (rise[LN_CLK]),
        .bit_val  (lvl[LN_DAT]),
        .load_stb (rise[LN_LE]),
        .frame    (frame)
    );

    twl_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .frame (frame),
        .regs  (regs),
        .upd   (upd),
        .err   (frame_err)
    );

    assign ref_word  = regs[SEL_REF];
    assign cnt_word  = regs[SEL_CNT];
    assign func_word = regs[SEL_FUNC];
    assign init_word = regs[SEL_INIT];
    assign ref_upd   = upd[SEL_REF];
    assign cnt_upd   = upd[SEL_CNT];
    assign func_upd  = upd[SEL_FUNC];
    assign init_upd  = upd[SEL_INIT];

    p_init_func_r6: assert property (@(posedge clk) disable iff (rst)
        init_upd |-> (func_upd && func_word == init_word));
    p_single_write_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_upd || cnt_upd || func_upd) |=> !(ref_upd || cnt_upd || func_upd));
endmodule

// File: tb/test_three_wire_loader.sv
module test_three_wire_loader;
    localparam int PW = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [PW-1:0] ref_word, cnt_word, func_word, init_word;
    logic ref_upd, cnt_upd, func_upd, init_upd, frame_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [PW-1:0] model [4];

    always #5 clk = ~clk;

    three_wire_loader i_three_wire_loader (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_word(ref_word), .cnt_word(cnt_word), .func_word(func_word), .init_word(init_word),
        .ref_upd(ref_upd), .cnt_upd(cnt_upd), .func_upd(func_upd), .init_upd(init_upd),
        .frame_err(frame_err)
    );

    function automatic logic [PW-1:0] reg_of(input int g);
        case (g)
            0: return ref_word;
            1: return cnt_word;
            2: return func_word;
            default: return init_word;
        endcase
    endfunction

    function automatic logic upd_of(input int g);
        case (g)
            0: return ref_upd;
            1: return cnt_upd;
            2: return func_upd;
            default: return init_upd;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        repeat (3) @(negedge clk);
    endtask

    task automatic shift_bits(input int n, input logic [63:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            tick();
            ser_clk = 1'b1;
            tick();
            ser_clk = 1'b0;
        end
        tick();
    endtask

    task automatic pulse_watch(output int first [4], output int width [4]);
        for (int g = 0; g < 4; g++) begin first[g] = 0; width[g] = 0; end
        ser_le = 1'b1;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 5) ser_le = 1'b0;
            for (int g = 0; g < 4; g++) begin
                if (upd_of(g)) begin
                    width[g]++;
                    if (first[g] == 0) first[g] = n;
                end
            end
        end
        tick();
    endtask

    task automatic good_word(input int sel, input logic [PW-1:0] pay);
        int first [4];
        int width [4];
        logic [3:0] mask;
        mask = 4'b0001 << sel;
        if (sel == 3) mask[2] = 1'b1;
        shift_bits(24, {40'd0, pay, sel[1:0]});
        pulse_watch(first, width);
        for (int g = 0; g < 4; g++) begin
            if (mask[g]) begin
                model[g] = pay;
                chk(width[g] == 1, "R7 strobe width", width[g], 1);
                chk(first[g] == 4, "R11 strobe latency", first[g], 4);
            end else begin
                chk(width[g] == 0, "R7 unselected strobe quiet", width[g], 0);
            end
        end
        if (sel == 3) chk(first[2] == first[3], "R6 same-cycle strobes", first[2], first[3]);
        for (int g = 0; g < 4; g++)
            chk(reg_of(g) == model[g],
                sel == 0 ? "R3 ref register" : sel == 1 ? "R4 cnt register" :
                sel == 2 ? "R5 func register" : "R6 init/func registers R2",
                reg_of(g), model[g]);
        chk(frame_err == 1'b0, "R10 error clear after good word", frame_err, 0);
    endtask

    task automatic bad_word(input int n);
        int first [4];
        int width [4];
        shift_bits(n, 64'hA5C3_96F0_5A3C_690F);
        pulse_watch(first, width);
        for (int g = 0; g < 4; g++) begin
            chk(width[g] == 0, n < 24 ? "R8 no strobe on short word" : "R9 no strobe on long word", width[g], 0);
            chk(reg_of(g) == model[g], n < 24 ? "R8 register kept" : "R9 register kept", reg_of(g), model[g]);
        end
        chk(frame_err == 1'b1, n < 24 ? "R8 error on short word" : "R9 error on long word", frame_err, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        for (int g = 0; g < 4; g++) model[g] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int g = 0; g < 4; g++) begin
            chk(reg_of(g) == '0, "R1 reset register", reg_of(g), 0);
            chk(upd_of(g) == 1'b0, "R1 reset strobe", upd_of(g), 0);
        end
        chk(frame_err == 1'b0, "R1 reset error flag", frame_err, 0);

        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < PW; b++) good_word(s, PW'(1) << b);
            good_word(s, 22'h3FFFFF);
            good_word(s, 22'h2AAAAA ^ PW'(s * 22'h01234B));
        end

        for (int n = 0; n <= 27; n++) begin
            if (n == 24) continue;
            bad_word(n);
            if (n % 4 == 0) good_word(n % 3, PW'(n * 22'h0F0F1));
        end
        good_word(3, 22'h155555);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule